// File: doc/BRIEF.md
# Paired Byte FIFO with Wrapping Occupancy Count

This block holds the two byte queues that sit between a serial line engine and a host register port. One queue carries received bytes from the line engine to the host. The other carries bytes the host writes towards the line engine for transmission. Each queue holds 256 bytes. Its occupancy is reported as an 8-bit count that wraps to 0 at 256 entries. A separate status byte tells the host whether each queue is empty, full or has overflowed, and whether the transmitter is still shifting a byte out.

Software reads the status byte through a strobe, and that read clears the overflow flags. The status value is captured in a register, so a flag is cleared only after a read has returned it. A 4-bit control register holds an enable bit and a reset bit for each direction. A reset bit acts on the next clock and then clears itself. The line engine and the host bus are modelled as plain push and pop strobes.

Top module: `uart_fifo_pair`

## Requirements
- R1: After the synchronous reset, both counts, the status byte, the control register and both read-data outputs are 0, so both queues start disabled.
- R2: Each queue returns bytes in the order they were pushed. Read data is registered: it appears on the cycle after the pop strobe and holds until the next pop strobe.
- R3: The count output is the number of stored bytes modulo 256. With 256 bytes stored, the count is 0 while the not-empty and full flags are both 1.
- R4: A push into a full queue is dropped and sets that queue's overflow flag. The stored bytes are unchanged. A push and a pop in the same cycle on a full queue pop one byte and drop the pushed byte.
- R5: A pop strobe on an empty queue leaves the pointers in place and loads read data 0.
- R6: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged.
- R7: A status read returns the flags as they stood in that cycle and clears both overflow flags. An overflow raised in the same cycle as the read is kept.
- R8: While a queue's enable bit is 0, its push strobes are ignored and its pop strobes return 0 without removing data.
- R9: Control bits: bit 0 enables the receive queue, bit 1 the transmit queue, bit 2 resets the receive queue and bit 3 resets the transmit queue. A reset bit reads back 1 for exactly one cycle after it is written. On the next clock it empties its queue and clears that queue's overflow flag, and in that cycle it wins over any push or pop.
- R10: The transmitter-busy status bit reports the line engine's shifting input as sampled on the status read.
- R11: Status bits: bit 0 receive not-empty, bit 1 receive full, bit 2 receive overflow, bit 3 transmit not-empty, bit 4 transmit full, bit 5 transmit overflow, bit 6 transmitter busy, bit 7 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tx_wr | input | 1 | Host push into the transmit queue |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_rd | input | 1 | Host pop from the receive queue |
| host_rx_data | output | 8 | Registered byte popped by the host |
| line_rx_vld | input | 1 | Line engine push into the receive queue |
| line_rx_data | input | 8 | Byte received from the line |
| line_tx_pop | input | 1 | Line engine pop from the transmit queue |
| line_tx_data | output | 8 | Registered byte handed to the line engine |
| line_tx_busy | input | 1 | Line engine is shifting a byte out |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value to write |
| ctl_rdata | output | 4 | Current control register |
| stat_rd | input | 1 | Status read strobe (clears overflow flags) |
| stat_rdata | output | 8 | Registered status byte |
| rx_count | output | 8 | Receive queue occupancy modulo 256 |
| tx_count | output | 8 | Transmit queue occupancy modulo 256 |

## Verification
The bench builds the block with its default parameters: 8-bit data and an 8-bit address, so each queue is 256 deep. At that depth the wrap of the count from 255 to 0 at the full point, the not-empty/full disambiguation and the pointer rollover past entry 255 are all reached within a few hundred cycles. Random phases alternate between push-heavy and pop-heavy bias so both queues repeatedly hit full and empty. Directed cases then cover overflow during a status read, pops on an empty queue, disabled queues and self-clearing resets.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // Status byte, MSB first
    typedef struct packed {
        logic zero;
        logic tx_busy;
        logic tx_ovf;
        logic tx_full;
        logic tx_nonempty;
        logic rx_ovf;
        logic rx_full;
        logic rx_nonempty;
    } stat_t;

    // Control register, MSB first
    typedef struct packed {
        logic tx_clr;
        logic rx_clr;
        logic tx_en;
        logic rx_en;
    } ctl_t;

    typedef struct packed {
        logic nonempty;
        logic full;
        logic ovf;
    } qflags_t;

    function automatic stat_t pack_status(input qflags_t rxf, input qflags_t txf,
                                          input logic busy);
        stat_t s;
        s.zero        = 1'b0;
        s.tx_busy     = busy;
        s.tx_ovf      = txf.ovf;
        s.tx_full     = txf.full;
        s.tx_nonempty = txf.nonempty;
        s.rx_ovf      = rxf.ovf;
        s.rx_full     = rxf.full;
        s.rx_nonempty = rxf.nonempty;
        return s;
    endfunction

    // Self-clearing bits drop unless rewritten
    function automatic ctl_t ctl_next(input ctl_t cur, input logic wr, input ctl_t wd);
        ctl_t n;
        if (wr) begin
            n = wd;
        end else begin
            n        = cur;
            n.tx_clr = 1'b0;
            n.rx_clr = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              ovf_ack,
    output logic [DATA_W-1:0] pop_data,
    output logic [ADDR_W-1:0] count,
    output uart_fifo_pkg::qflags_t flags
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [ADDR_W:0]   level;
    logic              ovf_q;
    logic              is_full, is_nonempty;
    logic              do_push, do_pop, ovf_set;

    assign is_full     = level[ADDR_W];
    assign is_nonempty = |level;

    assign do_push = en && !clr && push && !is_full;
    assign do_pop  = en && !clr && pop && is_nonempty;
    assign ovf_set = en && !clr && push && is_full;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= '0;
        end else begin
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_data <= '0;
        end else if (pop) begin
            pop_data <= do_pop ? mem[rd_ptr] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_set || (ovf_q && !ovf_ack);
        end
    end

    assign count          = level[ADDR_W-1:0];
    assign flags.nonempty = is_nonempty;
    assign flags.full     = is_full;
    assign flags.ovf      = ovf_q;

endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  uart_fifo_pkg::ctl_t wdata,
    output uart_fifo_pkg::ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= uart_fifo_pkg::ctl_next(q, wr, wdata);
        end
    end
endmodule

// File: rtl/fifo_stat_reg.sv
module fifo_stat_reg (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd,
    input  uart_fifo_pkg::stat_t live,
    output uart_fifo_pkg::stat_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (rd) begin
            q <= live;
        end
    end
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_tx_wr,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_rd,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              line_rx_vld,
    input  logic [DATA_W-1:0] line_rx_data,
    input  logic              line_tx_pop,
    output logic [DATA_W-1:0] line_tx_data,
    input  logic              line_tx_busy,
    input  logic              ctl_wr,
    input  logic [3:0]        ctl_wdata,
    output logic [3:0]        ctl_rdata,
    input  logic              stat_rd,
    output logic [7:0]        stat_rdata,
    output logic [ADDR_W-1:0] rx_count,
    output logic [ADDR_W-1:0] tx_count
);
    import uart_fifo_pkg::*;

    ctl_t    ctl_q;
    stat_t   stat_live, stat_q;
    qflags_t rx_flags, tx_flags;

    fifo_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_t'(ctl_wdata)),
        .q     (ctl_q)
    );

    byte_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl_q.rx_en),
        .clr       (ctl_q.rx_clr),
        .push      (line_rx_vld),
        .push_data (line_rx_data),
        .pop       (host_rx_rd),
        .ovf_ack   (stat_rd),
        .pop_data  (host_rx_data),
        .count     (rx_count),
        .flags     (rx_flags)
    );

    byte_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl_q.tx_en),
        .clr       (ctl_q.tx_clr),
        .push      (host_tx_wr),
        .push_data (host_tx_data),
        .pop       (line_tx_pop),
        .ovf_ack   (stat_rd),
        .pop_data  (line_tx_data),
        .count     (tx_count),
        .flags     (tx_flags)
    );

    assign stat_live = pack_status(rx_flags, tx_flags, line_tx_busy);

    fifo_stat_reg u_stat (
        .clk  (clk),
        .rst  (rst),
        .rd   (stat_rd),
        .live (stat_live),
        .q    (stat_q)
    );

    assign ctl_rdata  = ctl_q;
    assign stat_rdata = stat_q;

endmodule

// File: rtl/uart_fifo_pair_checker.sv
module uart_fifo_pair_checker #(
    parameter int ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   host_rx_rd,
    input logic [7:0]             host_rx_data,
    input logic                   line_rx_vld,
    input logic                   line_tx_busy,
    input logic                   stat_rd,
    input logic [7:0]             stat_rdata,
    input logic [ADDR_W-1:0]      rx_count,
    input uart_fifo_pkg::ctl_t    ctl_q,
    input uart_fifo_pkg::qflags_t rx_flags
);
    // R3: full queue reports a wrapped count with data present
    p_full_wraps_r3: assert property (@(posedge clk) disable iff (rst)
        rx_flags.full |-> (rx_flags.nonempty && rx_count == '0));

    // R5: popping an empty queue yields zero
    p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (host_rx_rd && !rx_flags.nonempty) |=> (host_rx_data == 8'h00));

    // R4: a push into a full queue leaves it full and flags overflow
    p_drop_when_full_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.rx_en && !ctl_q.rx_clr && line_rx_vld && !host_rx_rd && rx_flags.full)
        |=> (rx_flags.full && rx_flags.ovf));

    // R6: balanced traffic holds the count
    p_balanced_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.rx_en && !ctl_q.rx_clr && line_rx_vld && host_rx_rd &&
         rx_flags.nonempty && !rx_flags.full) |=> $stable(rx_count));

    // R7: overflow stays until a status read or a queue reset
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_flags.ovf && !stat_rd && !ctl_q.rx_clr) |=> rx_flags.ovf);

    // R7: the read that clears the flag returns it
    p_ovf_reported_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && rx_flags.ovf) |=> stat_rdata[2]);

    // R8: a disabled queue keeps its occupancy
    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.rx_en && !ctl_q.rx_clr) |=> $stable(rx_count));

    // R9: queue reset empties the queue and drops itself
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.rx_clr |=> (!rx_flags.nonempty && !rx_flags.ovf));

    // R10: busy bit follows the engine input on a read
    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (stat_rdata[6] == $past(line_tx_busy)));

    // R11: the top status bit is always zero
    p_msb_zero_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> !stat_rdata[7]);
endmodule

bind uart_fifo_pair uart_fifo_pair_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rx_rd   (host_rx_rd),
    .host_rx_data (host_rx_data),
    .line_rx_vld  (line_rx_vld),
    .line_tx_busy (line_tx_busy),
    .stat_rd      (stat_rd),
    .stat_rdata   (stat_rdata),
    .rx_count     (rx_count),
    .ctl_q        (ctl_q),
    .rx_flags     (rx_flags)
);

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_tx_wr, host_rx_rd, line_rx_vld, line_tx_pop, line_tx_busy;
    logic       ctl_wr, stat_rd;
    logic [7:0] host_tx_data, line_rx_data;
    logic [3:0] ctl_wdata;
    logic [7:0] host_rx_data, line_tx_data, stat_rdata, rx_count, tx_count;
    logic [3:0] ctl_rdata;

    always #4 clk = ~clk;

    uart_fifo_pair i_uart_fifo_pair (
        .clk(clk), .rst(rst),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .line_rx_vld(line_rx_vld), .line_rx_data(line_rx_data),
        .line_tx_pop(line_tx_pop), .line_tx_data(line_tx_data),
        .line_tx_busy(line_tx_busy),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .rx_count(rx_count), .tx_count(tx_count)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model
    logic [7:0] rxm [256];
    logic [7:0] txm [256];
    int rxh, rxn, txh, txn;
    bit rxovf, txovf;
    logic [3:0] mctl;
    logic [7:0] e_hrd, e_ltd, e_stat;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] live_stat(input bit busy);
        return {1'b0, busy, txovf, txn == 256, txn > 0, rxovf, rxn == 256, rxn > 0};
    endfunction

    task automatic model_rx(input bit push, input logic [7:0] d, input bit pop, input bit sr);
        bit dop, dpush, oset;
        if (mctl[2]) begin
            if (pop) e_hrd = 8'h00;
            rxn = 0; rxh = 0; rxovf = 0;
        end else begin
            dop   = mctl[0] && pop && rxn > 0;
            dpush = mctl[0] && push && rxn < 256;
            oset  = mctl[0] && push && rxn == 256;
            if (pop) e_hrd = dop ? rxm[rxh] : 8'h00;
            if (dpush) rxm[(rxh + rxn) % 256] = d;
            if (dop) begin rxh = (rxh + 1) % 256; rxn--; end
            if (dpush) rxn++;
            rxovf = oset || (rxovf && !sr);
        end
    endtask

    task automatic model_tx(input bit push, input logic [7:0] d, input bit pop, input bit sr);
        bit dop, dpush, oset;
        if (mctl[3]) begin
            if (pop) e_ltd = 8'h00;
            txn = 0; txh = 0; txovf = 0;
        end else begin
            dop   = mctl[1] && pop && txn > 0;
            dpush = mctl[1] && push && txn < 256;
            oset  = mctl[1] && push && txn == 256;
            if (pop) e_ltd = dop ? txm[txh] : 8'h00;
            if (dpush) txm[(txh + txn) % 256] = d;
            if (dop) begin txh = (txh + 1) % 256; txn--; end
            if (dpush) txn++;
            txovf = oset || (txovf && !sr);
        end
    endtask

    // One clock: drive at negedge, update model, check after the edge
    task automatic step(input bit hw, input logic [7:0] hwd, input bit hr,
                        input bit lv, input logic [7:0] ld, input bit lp,
                        input bit sr, input bit cw, input logic [3:0] cwd, input bit busy);
        host_tx_wr = hw; host_tx_data = hwd; host_rx_rd = hr;
        line_rx_vld = lv; line_rx_data = ld; line_tx_pop = lp;
        stat_rd = sr; ctl_wr = cw; ctl_wdata = cwd; line_tx_busy = busy;
        if (sr) e_stat = live_stat(busy);
        model_rx(lv, ld, hr, sr);
        model_tx(hw, hwd, lp, sr);
        mctl = cw ? cwd : (mctl & 4'b0011);
        @(negedge clk);
        chk("R2 rx data", host_rx_data, e_hrd);
        chk("R2 tx data", line_tx_data, e_ltd);
        chk("R3 rx count", rx_count, rxn % 256);
        chk("R3 tx count", tx_count, txn % 256);
        chk("R11 status", stat_rdata, e_stat);
        chk("R9 control", ctl_rdata, mctl);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic status(input bit busy);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, busy);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rxh = 0; rxn = 0; txh = 0; txn = 0; rxovf = 0; txovf = 0;
        mctl = 0; e_hrd = 0; e_ltd = 0; e_stat = 0;
        rst = 1;
        host_tx_wr = 0; host_tx_data = 0; host_rx_rd = 0; line_rx_vld = 0;
        line_rx_data = 0; line_tx_pop = 0; line_tx_busy = 0;
        ctl_wr = 0; ctl_wdata = 0; stat_rd = 0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 rx count", rx_count, 0);
        chk("R1 tx count", tx_count, 0);
        chk("R1 status", stat_rdata, 0);
        chk("R1 control", ctl_rdata, 0);
        chk("R1 rx data", host_rx_data, 0);
        chk("R1 tx data", line_tx_data, 0);
        rst = 0;

        // R8: disabled queues ignore strobes
        step(1, 8'h11, 0, 1, 8'h22, 0, 0, 0, 0, 0);
        chk("R8 rx count disabled", rx_count, 0);
        chk("R8 tx count disabled", tx_count, 0);
        status(0);
        chk("R8 status disabled", stat_rdata, 0);

        step(0, 0, 0, 0, 0, 0, 0, 1, 4'b0011, 0);

        // Random phases with alternating bias
        for (int ph = 0; ph < 8; ph++) begin
            int pin = (ph % 2 == 0) ? 85 : 25;
            for (int i = 0; i < 400; i++) begin
                bit cw = ($urandom % 100) == 0;
                step($urandom % 100 < pin, 8'($urandom), $urandom % 100 < 100 - pin,
                     $urandom % 100 < pin, 8'($urandom), $urandom % 100 < 100 - pin,
                     $urandom % 20 == 0, cw, {2'($urandom), 2'b11}, 1'($urandom));
            end
        end

        // Directed: fill receive queue to 256
        step(0, 0, 0, 0, 0, 0, 0, 1, 4'b0111, 0);
        idle();
        for (int i = 0; i < 256; i++) step(0, 0, 0, 1, 8'(i + 5), 0, 0, 0, 0, 0);
        chk("R3 count wraps at 256", rx_count, 0);
        status(0);
        chk("R3 nonempty and full at 256", stat_rdata[1:0], 2'b11);
        // R4: push while full is dropped
        step(0, 0, 0, 1, 8'hEE, 0, 0, 0, 0, 0);
        chk("R4 count after drop", rx_count, 0);
        // R7: overflow reported then cleared, new overflow during read kept
        step(0, 0, 0, 1, 8'hEF, 0, 1, 0, 0, 0);
        chk("R7 read returns overflow", stat_rdata[2], 1'b1);
        status(0);
        chk("R7 overflow raised during read kept", stat_rdata[2], 1'b1);
        status(0);
        chk("R7 overflow cleared by read", stat_rdata[2], 1'b0);
        // R4: push and pop on full: pop one, drop push
        step(0, 0, 1, 1, 8'hAB, 0, 0, 0, 0, 0);
        chk("R4 first byte intact", host_rx_data, 8'h05);
        chk("R4 count after full pop", rx_count, 255);
        // R6
        step(0, 0, 1, 1, 8'hCD, 0, 0, 0, 0, 0);
        chk("R6 balanced count", rx_count, 255);
        // Drain and verify order (R2)
        for (int i = 0; i < 255; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 last byte order", host_rx_data, 8'hCD);
        // R5: read empty
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 empty read zero", host_rx_data, 0);
        chk("R5 count stays zero", rx_count, 0);
        step(0, 0, 0, 1, 8'h77, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 pointers unmoved", host_rx_data, 8'h77);

        // R9: reset bits
        for (int i = 0; i < 4; i++) step(1, 8'(i), 0, 1, 8'(i), 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 4'b1111, 0);
        chk("R9 reset bits visible", ctl_rdata, 4'b1111);
        step(1, 8'h99, 0, 1, 8'h99, 0, 0, 0, 0, 0);
        chk("R9 reset self clears", ctl_rdata, 4'b0011);
        chk("R9 rx emptied", rx_count, 0);
        chk("R9 tx emptied", tx_count, 0);

        // R10: busy reported
        status(1);
        chk("R10 busy set", stat_rdata[6], 1'b1);
        status(0);
        chk("R10 busy clear", stat_rdata[6], 1'b0);

        // R8: pops on disabled queue return zero and keep data
        step(1, 8'h3C, 0, 1, 8'h3C, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 4'b0000, 0);
        step(0, 0, 1, 0, 0, 1, 0, 0, 0, 0);
        chk("R8 disabled pop zero", host_rx_data, 0);
        chk("R8 disabled keeps data", rx_count, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 4'b0011, 0);
        step(0, 0, 1, 0, 0, 1, 0, 0, 0, 0);
        chk("R2 tx byte after enable", line_tx_data, 8'h3C);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule